// File: doc/BRIEF.md
# Compact JTAG Escape and Activation Tracker

This block listens to a two-wire compact JTAG link: a test clock line and a bidirectional data line. Both are sampled on a fast system clock. While the test clock is high, the data line normally holds still. Each toggle of the data line during that high phase is an escape edge. The block counts these edges and decides at the next test clock rising edge whether they formed an escape sequence.

An escape of six edges opens the online activation phase. The tracker then counts test clock rising edges and reports which activation sub-field is passing on the wire. The field map has a short 12-bit form. It switches to a long 36-bit form when the data value at the eighth position is low. When the position count passes the active length, the link enters the single-wire scan mode. The block then raises a one-cycle request to reset the TAP state tracker. An escape of eight or more edges returns the link to standard four-wire operation.

A downstream logger can read the mode output directly. It can also capture each change on a one-cycle valid strobe.

Top module: `cjtag_link_tracker`

## Requirements
- R1: After a synchronous active-high reset, mode_o is 0 (four-wire), and field_valid_o and tap_reset_o are low.
- R2: Data-line toggles count as escape edges only while the test clock is high. Toggles during the low phase never change the mode.
- R3: The escape count is evaluated at the next test clock rising edge and then cleared. Edges from two separate high phases never add up.
- R4: A count of exactly 6 starts activation. The evaluating rising edge is position 1, so mode_o becomes 1 (activation code).
- R5: A count of 8 or more sets mode_o to 0 (four-wire). This applies from any mode, including during activation and from the single-wire scan mode.
- R6: Counts of 0 to 5 and of 7 leave the mode unchanged. During activation, position counting continues across such an escape.
- R7: In the short form, rising edges at positions 1–4 give mode 1 (activation code), positions 5–8 give mode 2 (extension code), and positions 9–12 give mode 3 (check packet).
- R8: If the data line is 0 at the rising edge of position 8, the long form applies. Positions 9–13 give mode 4, 14–16 mode 5, 17–18 mode 6, 19–23 mode 7, 24–25 mode 8, 26–27 mode 9, 28–32 mode 10 and 33–36 mode 3.
- R9: At the rising edge where the position exceeds the active length (13 in the short form, 37 in the long form), mode_o becomes 11 (single-wire scan). tap_reset_o pulses high for exactly one system clock.
- R10: field_valid_o is high for exactly one system clock in each cycle where mode_o takes a new value, and low at all other times.
- R11: In four-wire or single-wire scan mode, rising edges without a qualifying escape leave mode_o unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the test clock |
| rst | input | 1 | Synchronous active-high reset |
| tckc_i | input | 1 | Raw test clock line (asynchronous) |
| tmsc_i | input | 1 | Raw data line value (asynchronous) |
| mode_o | output | 4 | Link mode code (0 four-wire, 1–10 activation sub-fields, 11 single-wire scan) |
| field_valid_o | output | 1 | One-cycle strobe when mode_o changes |
| tap_reset_o | output | 1 | One-cycle TAP reset request on completion of activation |

## Verification
The bench sweeps escape lengths from 0 to 10 edges. A tracker with an off-by-one threshold would either enter activation at 5 or 7 edges, or fail to fall back to four-wire at exactly 8. Toggles during the low phase, and an escape split evenly across two high phases, must not activate. A design that counts regardless of clock level, or that forgets to clear at the rising edge, would activate wrongly in those cases. Full walks through both the 12-bit and 36-bit field maps catch a misplaced sub-field boundary, a long-form decision taken at the wrong position, or a completion that fires one edge early or late. Counting strobe cycles against expected mode changes exposes a strobe that sticks high or is missed.

// File: rtl/cjtag_trk_pkg.sv
`timescale 1ns/1ps
package cjtag_trk_pkg;

    typedef enum logic [3:0] {
        LINK_FOURWIRE = 4'd0,
        LINK_ACT_CODE = 4'd1,
        LINK_EXT_CODE = 4'd2,
        LINK_CHECK    = 4'd3,
        LINK_SPARE    = 4'd4,
        LINK_PDELAY   = 4'd5,
        LINK_PREVERSE = 4'd6,
        LINK_PSTATE   = 4'd7,
        LINK_READY    = 4'd8,
        LINK_DELAY    = 4'd9,
        LINK_SCANFMT  = 4'd10,
        LINK_OSCAN1   = 4'd11
    } link_mode_e;

    // Escape thresholds
    localparam int unsigned ESC_ACTIVATE = 6;
    localparam int unsigned ESC_FOURWIRE = 8;

    // Activation field lengths and the position that selects the long form
    localparam int unsigned SHORT_LEN       = 12;
    localparam int unsigned LONG_LEN        = 36;
    localparam int unsigned LONG_DECIDE_POS = 8;

    // Last position of each sub-field
    localparam int unsigned ACT_END   = 4;
    localparam int unsigned EXT_END   = 8;
    localparam int unsigned SPARE_END = 13;
    localparam int unsigned PDLY_END  = 16;
    localparam int unsigned PREV_END  = 18;
    localparam int unsigned PST_END   = 23;
    localparam int unsigned RDY_END   = 25;
    localparam int unsigned DLY_END   = 27;
    localparam int unsigned SFMT_END  = 32;

endpackage

// File: rtl/cjtag_sync.sv
`timescale 1ns/1ps
module cjtag_sync #(
    parameter int unsigned WIDTH  = 2,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);

    logic [WIDTH-1:0] stage_d [STAGES];
    logic [WIDTH-1:0] stage_q [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_comb stage_d[g] = d_i;
        end else begin : g_rest
            always_comb stage_d[g] = stage_q[g-1];
        end

        always_ff @(posedge clk) begin
            if (rst) stage_q[g] <= '0;
            else     stage_q[g] <= stage_d[g];
        end
    end

    assign q_o = stage_q[STAGES-1];

endmodule

// File: rtl/cjtag_escape_counter.sv
`timescale 1ns/1ps
module cjtag_escape_counter #(
    parameter int unsigned ESC_CNT_W = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 tckc_s_i,
    input  logic                 tmsc_s_i,
    output logic                 rise_o,
    output logic                 tms_o,
    output logic [ESC_CNT_W-1:0] esc_cnt_o
);

    localparam logic [ESC_CNT_W-1:0] CNT_MAX = '1;

    typedef struct packed {
        logic                 tckc;
        logic                 tmsc;
        logic [ESC_CNT_W-1:0] cnt;
    } esc_state_t;

    esc_state_t st_d, st_q;
    logic       toggle_hi;

    always_comb begin
        st_d      = st_q;
        st_d.tckc = tckc_s_i;
        st_d.tmsc = tmsc_s_i;
        // a toggle counts only when the clock was high on both samples
        toggle_hi = tckc_s_i && st_q.tckc && (tmsc_s_i != st_q.tmsc);
        if (rise_o) begin
            st_d.cnt = '0;
        end else if (toggle_hi && (st_q.cnt != CNT_MAX)) begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign rise_o    = tckc_s_i && !st_q.tckc;
    assign tms_o     = tmsc_s_i;
    assign esc_cnt_o = st_q.cnt;

endmodule

// File: rtl/cjtag_activation_walker.sv
`timescale 1ns/1ps
module cjtag_activation_walker
    import cjtag_trk_pkg::*;
#(
    parameter int unsigned ESC_CNT_W = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 rise_i,
    input  logic                 tms_i,
    input  logic [ESC_CNT_W-1:0] esc_cnt_i,
    output link_mode_e           mode_o,
    output logic                 strobe_o,
    output logic                 tap_rst_o
);

    localparam int unsigned POS_W = $clog2(LONG_LEN + 2);

    typedef struct packed {
        link_mode_e       mode;
        logic [POS_W-1:0] pos;
        logic             long_form;
        logic             strobe;
        logic             tap_rst;
    } walk_state_t;

    walk_state_t      st_d, st_q;
    link_mode_e       m_tmp;
    logic [POS_W-1:0] p_tmp;
    logic             lf_tmp;
    logic             in_act;

    function automatic link_mode_e field_of(input logic [POS_W-1:0] p, input logic lf);
        if (p <= POS_W'(ACT_END))   return LINK_ACT_CODE;
        if (p <= POS_W'(EXT_END))   return LINK_EXT_CODE;
        if (!lf)                    return LINK_CHECK;
        if (p <= POS_W'(SPARE_END)) return LINK_SPARE;
        if (p <= POS_W'(PDLY_END))  return LINK_PDELAY;
        if (p <= POS_W'(PREV_END))  return LINK_PREVERSE;
        if (p <= POS_W'(PST_END))   return LINK_PSTATE;
        if (p <= POS_W'(RDY_END))   return LINK_READY;
        if (p <= POS_W'(DLY_END))   return LINK_DELAY;
        if (p <= POS_W'(SFMT_END))  return LINK_SCANFMT;
        return LINK_CHECK;
    endfunction

    always_comb begin
        st_d         = st_q;
        st_d.strobe  = 1'b0;
        st_d.tap_rst = 1'b0;
        m_tmp        = st_q.mode;
        p_tmp        = st_q.pos;
        lf_tmp       = st_q.long_form;
        in_act       = 1'b0;
        if (rise_i) begin
            // escape evaluation comes first on this edge
            if (esc_cnt_i >= ESC_CNT_W'(ESC_FOURWIRE)) begin
                m_tmp = LINK_FOURWIRE;
            end else if (esc_cnt_i == ESC_CNT_W'(ESC_ACTIVATE)) begin
                m_tmp  = LINK_ACT_CODE;
                p_tmp  = '0;
                lf_tmp = 1'b0;
            end
            in_act = (m_tmp != LINK_FOURWIRE) && (m_tmp != LINK_OSCAN1);
            if (in_act) begin
                p_tmp = p_tmp + 1'b1;
                if ((p_tmp == POS_W'(LONG_DECIDE_POS)) && !tms_i) lf_tmp = 1'b1;
                if (p_tmp > (lf_tmp ? POS_W'(LONG_LEN) : POS_W'(SHORT_LEN))) begin
                    m_tmp        = LINK_OSCAN1;
                    st_d.tap_rst = 1'b1;
                end else begin
                    m_tmp = field_of(p_tmp, lf_tmp);
                end
            end
            st_d.strobe    = (m_tmp != st_q.mode);
            st_d.mode      = m_tmp;
            st_d.pos       = p_tmp;
            st_d.long_form = lf_tmp;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q      <= '0;
            st_q.mode <= LINK_FOURWIRE;
        end else begin
            st_q <= st_d;
        end
    end

    assign mode_o    = st_q.mode;
    assign strobe_o  = st_q.strobe;
    assign tap_rst_o = st_q.tap_rst;

endmodule

// File: rtl/cjtag_link_tracker.sv
`timescale 1ns/1ps
module cjtag_link_tracker
    import cjtag_trk_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned ESC_CNT_W   = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tckc_i,
    input  logic       tmsc_i,
    output logic [3:0] mode_o,
    output logic       field_valid_o,
    output logic       tap_reset_o
);

    logic [1:0]           line_s;
    logic                 tckc_rise;
    logic                 tms_at_rise;
    logic [ESC_CNT_W-1:0] esc_cnt;
    link_mode_e           mode_w;

    cjtag_sync #(
        .WIDTH  (2),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk (clk),
        .rst (rst),
        .d_i ({tckc_i, tmsc_i}),
        .q_o (line_s)
    );

    cjtag_escape_counter #(
        .ESC_CNT_W (ESC_CNT_W)
    ) u_esc (
        .clk       (clk),
        .rst       (rst),
        .tckc_s_i  (line_s[1]),
        .tmsc_s_i  (line_s[0]),
        .rise_o    (tckc_rise),
        .tms_o     (tms_at_rise),
        .esc_cnt_o (esc_cnt)
    );

    cjtag_activation_walker #(
        .ESC_CNT_W (ESC_CNT_W)
    ) u_walk (
        .clk       (clk),
        .rst       (rst),
        .rise_i    (tckc_rise),
        .tms_i     (tms_at_rise),
        .esc_cnt_i (esc_cnt),
        .mode_o    (mode_w),
        .strobe_o  (field_valid_o),
        .tap_rst_o (tap_reset_o)
    );

    assign mode_o = mode_w;

endmodule

// File: rtl/cjtag_link_tracker_chk.sv
`timescale 1ns/1ps
module cjtag_link_tracker_chk
    import cjtag_trk_pkg::*;
#(
    parameter int unsigned ESC_CNT_W = 4
) (
    input logic                 clk,
    input logic                 rst,
    input logic [3:0]           mode,
    input logic                 strobe,
    input logic                 tap_rst,
    input logic                 rise,
    input logic [ESC_CNT_W-1:0] esc_cnt
);

    a_r4_six_edges_activate: assert property (@(posedge clk) disable iff (rst)
        (rise && esc_cnt == ESC_CNT_W'(ESC_ACTIVATE)) |=> (mode == 4'(LINK_ACT_CODE)));

    a_r5_eight_edges_fourwire: assert property (@(posedge clk) disable iff (rst)
        (rise && esc_cnt >= ESC_CNT_W'(ESC_FOURWIRE)) |=> (mode == 4'(LINK_FOURWIRE)));

    a_r9_reset_req_on_entry: assert property (@(posedge clk) disable iff (rst)
        tap_rst |-> (mode == 4'(LINK_OSCAN1) && $past(mode) != 4'(LINK_OSCAN1)));

    a_r9_reset_req_single: assert property (@(posedge clk) disable iff (rst)
        tap_rst |=> !tap_rst);

    a_r10_strobe_on_change: assert property (@(posedge clk) disable iff (rst)
        (mode != $past(mode)) |-> strobe);

    a_r10_strobe_only_change: assert property (@(posedge clk) disable iff (rst)
        strobe |-> (mode != $past(mode)));

    a_r11_mode_moves_on_rise: assert property (@(posedge clk) disable iff (rst)
        !$past(rise) |-> $stable(mode));

    a_r1_mode_legal: assert property (@(posedge clk) disable iff (rst)
        mode <= 4'(LINK_OSCAN1));

endmodule

bind cjtag_link_tracker cjtag_link_tracker_chk #(
    .ESC_CNT_W (ESC_CNT_W)
) u_chk (
    .clk     (clk),
    .rst     (rst),
    .mode    (mode_o),
    .strobe  (field_valid_o),
    .tap_rst (tap_reset_o),
    .rise    (tckc_rise),
    .esc_cnt (esc_cnt)
);

// File: tb/cjtag_link_tracker_bench.sv
`timescale 1ns/1ps
module cjtag_link_tracker_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tckc = 1'b0;
    logic       tmsc = 1'b0;
    logic [3:0] mode_o;
    logic       field_valid_o;
    logic       tap_reset_o;

    int checks = 0;
    int fails  = 0;
    int exp_mode = 0;
    int exp_pos  = 0;
    int exp_len  = 12;
    int pending  = 0;
    int exp_fv   = 0;
    int exp_tr   = 0;
    int seen_fv  = 0;
    int seen_tr  = 0;
    bit done     = 1'b0;

    always #2.5 clk = ~clk;

    cjtag_link_tracker u_cjtag_link_tracker (
        .clk           (clk),
        .rst           (rst),
        .tckc_i        (tckc),
        .tmsc_i        (tmsc),
        .mode_o        (mode_o),
        .field_valid_o (field_valid_o),
        .tap_reset_o   (tap_reset_o)
    );

    always @(negedge clk) begin
        if (!rst) begin
            if (field_valid_o) seen_fv++;
            if (tap_reset_o)   seen_tr++;
        end
    end

    task automatic wait_clks(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic int field_code(input int p, input int len);
        if (p <= 4)     return 1;
        if (p <= 8)     return 2;
        if (len == 12)  return 3;
        if (p <= 13)    return 4;
        if (p <= 16)    return 5;
        if (p <= 18)    return 6;
        if (p <= 23)    return 7;
        if (p <= 25)    return 8;
        if (p <= 27)    return 9;
        if (p <= 32)    return 10;
        return 3;
    endfunction

    task automatic model_rise(input bit tms);
        int old = exp_mode;
        if (pending >= 8) begin
            exp_mode = 0;
        end else if (pending == 6) begin
            exp_mode = 1;
            exp_pos  = 0;
            exp_len  = 12;
        end
        pending = 0;
        if (exp_mode != 0 && exp_mode != 11) begin
            exp_pos++;
            if (exp_pos == 8 && !tms) exp_len = 36;
            if (exp_pos > exp_len) begin
                exp_mode = 11;
                exp_tr++;
            end else begin
                exp_mode = field_code(exp_pos, exp_len);
            end
        end
        if (exp_mode != old) exp_fv++;
    endtask

    task automatic check_mode(input string tag);
        checks++;
        if (mode_o !== 4'(exp_mode)) begin
            fails++;
            $display("FAIL %s mode_o=%0d expected %0d", tag, mode_o, exp_mode);
        end
    endtask

    // one test clock period: set data, rise, check, toggle n times while high, fall
    task automatic cyc(input bit tms, input int toggles, input string tag);
        tmsc = tms;
        wait_clks(4);
        tckc = 1'b1;
        model_rise(tms);
        wait_clks(6);
        check_mode(tag);
        for (int i = 0; i < toggles; i++) begin
            tmsc = ~tmsc;
            wait_clks(4);
        end
        pending = (pending + toggles > 15) ? 15 : pending + toggles;
        tckc = 1'b0;
        wait_clks(4);
    endtask

    task automatic low_toggles(input int n);
        for (int i = 0; i < n; i++) begin
            tmsc = ~tmsc;
            wait_clks(4);
        end
    endtask

    initial begin
        wait_clks(150000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        wait_clks(5);
        rst = 1'b0;
        wait_clks(3);
        // R1 reset state
        check_mode("R1");
        checks++;
        if (field_valid_o !== 1'b0 || tap_reset_o !== 1'b0) begin
            fails++;
            $display("FAIL R1 strobes=%b%b expected 00", field_valid_o, tap_reset_o);
        end

        // R11 plain rises in four-wire
        cyc(1'b1, 0, "R11");
        cyc(1'b0, 0, "R11");

        // R2 toggles while clock low are ignored
        low_toggles(6);
        cyc(1'b1, 0, "R2");
        cyc(1'b1, 0, "R2");

        // R3 split escape 3+3 never activates
        cyc(1'b0, 3, "R3");
        cyc(1'b0, 3, "R3");
        cyc(1'b0, 0, "R3");

        // R6 seven and five edges leave mode unchanged
        cyc(1'b0, 7, "R6");
        cyc(1'b0, 0, "R6");
        cyc(1'b0, 5, "R6");
        cyc(1'b0, 0, "R6");

        // R4 + R7 short activation walk, R9 completion
        cyc(1'b1, 6, "R4");
        for (int p = 1; p <= 13; p++) cyc(1'b1, 0, (p <= 12) ? "R7" : "R9");

        // R11 rises in single-wire scan mode
        for (int k = 0; k < 3; k++) cyc(1'b0, 0, "R11");

        // R8 long activation walk (data 0 at position 8), R9 completion
        cyc(1'b1, 6, "R4");
        for (int p = 1; p <= 37; p++) cyc((p == 8) ? 1'b0 : 1'b1, 0, (p <= 36) ? "R8" : "R9");

        // R5 back to four-wire from single-wire scan
        cyc(1'b0, 8, "R5");
        cyc(1'b0, 0, "R5");

        // R6 seven edges during activation keep counting, R5 exit mid-walk
        cyc(1'b1, 6, "R4");
        cyc(1'b1, 0, "R4");
        cyc(1'b1, 0, "R7");
        cyc(1'b1, 7, "R6");
        cyc(1'b1, 0, "R6");
        cyc(1'b1, 9, "R5");
        cyc(1'b1, 0, "R5");

        // R4/R6/R5 sweep of escape lengths from four-wire
        for (int n = 0; n <= 10; n++) begin
            cyc(1'b1, n, "R6");
            cyc(1'b1, 0, (n == 6) ? "R4" : "R6");
            cyc(1'b1, 8, "R5");
            cyc(1'b1, 0, "R5");
        end

        wait_clks(4);
        // R10 strobe cycles equal the number of mode changes
        checks++;
        if (seen_fv != exp_fv) begin
            fails++;
            $display("FAIL R10 field_valid cycles=%0d expected %0d", seen_fv, exp_fv);
        end
        // R9 reset request cycles equal completions
        checks++;
        if (seen_tr != exp_tr) begin
            fails++;
            $display("FAIL R9 tap_reset cycles=%0d expected %0d", seen_tr, exp_tr);
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule